// File: doc/BRIEF.md
# Host Byte FIFO with Command Capture

This block is the byte queue between a host register port and a transfer engine. It is sixteen bytes deep and has a separate read pointer and write pointer, plus a signed occupancy count. A host write goes into the queue. While the capture flag is set, a host write goes instead into a separate command buffer, at the next free index. A host read takes one byte from the queue and gives a one-cycle interrupt request.

What a read returns depends on the bus phase that the control logic presents. In the outbound data phase the host gets zero, but the occupancy still drops by one. When the queue drains, both pointers go back to slot zero. The control logic can also load a two-byte response, which replaces the queue contents with a status byte and a zero byte.

Top module: `hfifo_top`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), `level`, `rd_data`, `irq`, `resp_flags`, `capturing` and `cmd_len` are all zero.
- R2: A host write applies only when `rd_en` and `resp_load` are both low, `capturing` is low and `level` is below 15. It stores `wr_data` and adds one to `level`. Bytes are read back in the order they were written.
- R3: A host write arriving with `level` at 15 is dropped. `level` stays at 15 and the queued bytes are not altered.
- R4: A host write while `capturing` is high stores `wr_data` at command index `cmd_len` and adds one to `cmd_len`. The queue and `level` stay unchanged. Once `cmd_len` has reached CMD_DEPTH, further captured writes are dropped. `cmd_byte` shows the entry at `cmd_idx`.
- R5: A read (`rd_en` high, `resp_load` low) with `level` above zero removes one byte. After the next edge, `rd_data` holds that byte and `irq` is high for exactly that one cycle.
- R6: While `phase[2:1]` is 2'b00 (outbound data phase), a read with `level` above zero returns 0x00 and subtracts one from `level`, but leaves the read pointer where it is. A later read in another phase therefore returns the byte that was skipped.
- R7: A read with `level` at zero leaves `rd_data` at its previous value, keeps `irq` low and keeps `level` at zero.
- R8: When a read brings `level` to zero, both pointers return to slot zero, so the next byte written is the next byte read.
- R9: `resp_load` puts `resp_status` and then 0x00 in the queue, sets `level` to 2 and `resp_flags` to 2, and clears both pointers. It takes priority over a read or a write in the same cycle.
- R10: When `rd_en` and `wr_en` are both high, only the read is performed and the written byte is dropped.
- R11: `cap_set` raises `capturing` and sets `cmd_len` to zero. `cap_clr` lowers `capturing` and keeps `cmd_len`. If both are high, `cap_clr` wins. Each takes effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Host write strobe for the queue address |
| wr_data | input | 8 | Host write byte |
| rd_en | input | 1 | Host read strobe for the queue address |
| rd_data | output | 8 | Latched byte from the last read |
| irq | output | 1 | One-cycle request after each read that removed a byte |
| phase | input | 3 | Current bus phase from the control logic |
| level | output | 5 | Queue occupancy |
| cap_set | input | 1 | Enter command capture and clear the command length |
| cap_clr | input | 1 | Leave command capture |
| capturing | output | 1 | Command capture is active |
| cmd_len | output | 6 | Number of captured command bytes |
| cmd_idx | input | 5 | Command buffer read index |
| cmd_byte | output | 8 | Command buffer entry at `cmd_idx` |
| resp_load | input | 1 | Load a two-byte status response |
| resp_status | input | 8 | Status byte for the response |
| resp_flags | output | 8 | Flags value, set to 2 by a response load |

## Verification
The checker watches a fixed set of rules on every cycle:
- the occupancy ceiling and overrun refusal;
- the interrupt request following exactly the reads that removed a byte;
- zero data in the outbound phase;
- an unchanged occupancy during capture;
- the state left by a response load;
- pointer clearing on a drain.

Other behaviour only shows up across a sequence of reads and writes, so only the bench scenarios can show it. This covers the byte order through the queue, the replay of a byte skipped in the outbound phase, the effect of the pointer reset on the next byte, and the command buffer contents. The bench checks these against a reference model driven with random and directed traffic.

// File: rtl/hfifo_pkg.sv
// Package: shared action type and phase decode for the host byte FIFO.
// Assumes phase bits [2:1] equal to zero mark the outbound data phase.
package hfifo_pkg;

    typedef enum logic [1:0] {
        ACT_IDLE = 2'd0,
        ACT_PUSH = 2'd1,
        ACT_POP  = 2'd2,
        ACT_LOAD = 2'd3
    } fifo_act_e;

    function automatic logic is_outbound(input logic [2:0] ph);
        return (ph[2:1] == 2'b00);
    endfunction

endpackage

// File: rtl/hfifo_store.sv
// Module: data queue storage with read/write pointers and signed occupancy.
// Performs one action per cycle (push, pop, response load). Assumes the
// caller has already resolved priority; overrun is refused here.
module hfifo_store
    import hfifo_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int W     = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  fifo_act_e                   act,
    input  logic [W-1:0]                push_byte,
    input  logic                        outbound,
    input  logic [W-1:0]                resp_byte,
    output logic [W-1:0]                rd_q,
    output logic                        pop_irq,
    output logic signed [$clog2(DEPTH):0] occ,
    output logic [$clog2(DEPTH)-1:0]    rptr,
    output logic [$clog2(DEPTH)-1:0]    wptr
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int OCC_W = PTR_W + 1;
    localparam logic signed [OCC_W-1:0] OCC_ONE   = OCC_W'(1);
    localparam logic signed [OCC_W-1:0] OCC_ZERO  = '0;
    localparam logic signed [OCC_W-1:0] OCC_LIMIT = OCC_W'(DEPTH - 1);
    localparam logic signed [OCC_W-1:0] OCC_RESP  = OCC_W'(2);
    localparam logic [PTR_W-1:0]        PTR_ONE   = PTR_W'(1);

    logic [W-1:0] mem [DEPTH];

    // Purpose: storage array writes (push and response load).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (act == ACT_PUSH && occ != OCC_LIMIT) begin
            mem[wptr] <= push_byte;
        end else if (act == ACT_LOAD) begin
            mem[0] <= resp_byte;
            mem[1] <= '0;
        end
    end

    // Purpose: pointers, occupancy, read latch and interrupt pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rptr    <= '0;
            wptr    <= '0;
            occ     <= '0;
            rd_q    <= '0;
            pop_irq <= 1'b0;
        end else begin
            pop_irq <= 1'b0;
            case (act)
                ACT_PUSH: begin
                    if (occ != OCC_LIMIT) begin
                        wptr <= wptr + PTR_ONE;
                        occ  <= occ + OCC_ONE;
                    end
                end
                ACT_POP: begin
                    if (occ > OCC_ZERO) begin
                        occ     <= occ - OCC_ONE;
                        pop_irq <= 1'b1;
                        if (outbound) begin
                            rd_q <= '0;
                        end else begin
                            rd_q <= mem[rptr];
                            rptr <= rptr + PTR_ONE;
                        end
                        if (occ == OCC_ONE) begin
                            rptr <= '0;
                            wptr <= '0;
                        end
                    end else begin
                        rptr <= '0;
                        wptr <= '0;
                    end
                end
                ACT_LOAD: begin
                    occ  <= OCC_RESP;
                    rptr <= '0;
                    wptr <= '0;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/hfifo_cmdbuf.sv
// Module: command capture flag and command byte buffer.
// Captured writes fill entries in order until CMD_DEPTH is reached; later
// ones are dropped. The read port is combinational.
module hfifo_cmdbuf #(
    parameter int CMD_DEPTH = 32,
    parameter int W         = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           set_cap,
    input  logic                           clr_cap,
    input  logic                           push,
    input  logic [W-1:0]                   push_byte,
    input  logic [$clog2(CMD_DEPTH)-1:0]   idx,
    output logic                           cap_q,
    output logic [$clog2(CMD_DEPTH+1)-1:0] len,
    output logic [W-1:0]                   rd_byte
);
    localparam int IDX_W = $clog2(CMD_DEPTH);
    localparam int LEN_W = $clog2(CMD_DEPTH + 1);
    localparam logic [LEN_W-1:0] LEN_FULL = LEN_W'(CMD_DEPTH);
    localparam logic [LEN_W-1:0] LEN_ONE  = LEN_W'(1);

    logic [W-1:0] cbuf [CMD_DEPTH];

    // Purpose: combinational read of one command entry.
    assign rd_byte = cbuf[idx];

    // Purpose: command buffer entry writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < CMD_DEPTH; i++) cbuf[i] <= '0;
        end else if (push && len != LEN_FULL) begin
            cbuf[len[IDX_W-1:0]] <= push_byte;
        end
    end

    // Purpose: capture flag and command length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q <= 1'b0;
            len   <= '0;
        end else if (clr_cap) begin
            cap_q <= 1'b0;
            if (push && len != LEN_FULL) len <= len + LEN_ONE;
        end else if (set_cap) begin
            cap_q <= 1'b1;
            len   <= '0;
        end else if (push && len != LEN_FULL) begin
            len <= len + LEN_ONE;
        end
    end
endmodule

// File: rtl/hfifo_top.sv
// Module: host byte FIFO with command capture (top).
// Resolves one queue action per cycle: response load first, then a read,
// then a write. A write goes to the command buffer while capture is active.
// Assumes a single host access per cycle in normal use.
module hfifo_top
    import hfifo_pkg::*;
#(
    parameter int DEPTH     = 16,
    parameter int CMD_DEPTH = 32,
    parameter int W         = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [W-1:0]                      wr_data,
    input  logic                              rd_en,
    output logic [W-1:0]                      rd_data,
    output logic                              irq,
    input  logic [2:0]                        phase,
    output logic [$clog2(DEPTH):0]            level,
    input  logic                              cap_set,
    input  logic                              cap_clr,
    output logic                              capturing,
    output logic [$clog2(CMD_DEPTH+1)-1:0]    cmd_len,
    input  logic [$clog2(CMD_DEPTH)-1:0]      cmd_idx,
    output logic [W-1:0]                      cmd_byte,
    input  logic                              resp_load,
    input  logic [W-1:0]                      resp_status,
    output logic [W-1:0]                      resp_flags
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int OCC_W = PTR_W + 1;

    fifo_act_e                 act;
    logic                      cmd_push;
    logic signed [OCC_W-1:0]   occ;
    logic [PTR_W-1:0]          rptr;
    logic [PTR_W-1:0]          wptr;

    // Purpose: choose this cycle's queue action by priority.
    always_comb begin
        if (resp_load)                 act = ACT_LOAD;
        else if (rd_en)                act = ACT_POP;
        else if (wr_en && !capturing)  act = ACT_PUSH;
        else                           act = ACT_IDLE;
    end

    // Purpose: route a host write into the command buffer during capture.
    assign cmd_push = wr_en && capturing && !rd_en && !resp_load;
    assign level    = occ;

    hfifo_store #(.DEPTH(DEPTH), .W(W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .act       (act),
        .push_byte (wr_data),
        .outbound  (is_outbound(phase)),
        .resp_byte (resp_status),
        .rd_q      (rd_data),
        .pop_irq   (irq),
        .occ       (occ),
        .rptr      (rptr),
        .wptr      (wptr)
    );

    hfifo_cmdbuf #(.CMD_DEPTH(CMD_DEPTH), .W(W)) u_cmd (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_cap   (cap_set),
        .clr_cap   (cap_clr),
        .push      (cmd_push),
        .push_byte (wr_data),
        .idx       (cmd_idx),
        .cap_q     (capturing),
        .len       (cmd_len),
        .rd_byte   (cmd_byte)
    );

    // Purpose: flags value reported after a response load.
    always_ff @(posedge clk) begin
        if (!rst_n)         resp_flags <= '0;
        else if (resp_load) resp_flags <= W'(2);
    end
endmodule

// File: rtl/hfifo_checker.sv
// Module: cycle-level property checks for hfifo_top, attached by bind.
module hfifo_checker #(
    parameter int DEPTH = 16,
    parameter int W     = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       wr_en,
    input logic                       rd_en,
    input logic                       resp_load,
    input logic                       capturing,
    input logic [2:0]                 phase,
    input logic [$clog2(DEPTH):0]     level,
    input logic [W-1:0]               rd_data,
    input logic                       irq,
    input logic [W-1:0]               resp_flags,
    input logic [$clog2(DEPTH)-1:0]   rptr,
    input logic [$clog2(DEPTH)-1:0]   wptr
);
    localparam int OCC_W = $clog2(DEPTH) + 1;
    localparam logic [OCC_W-1:0] LIM = OCC_W'(DEPTH - 1);
    localparam logic [OCC_W-1:0] ONE = OCC_W'(1);
    localparam logic [OCC_W-1:0] TWO = OCC_W'(2);

    // R3: occupancy never passes the usable limit
    p_ceiling_r3: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LIM);

    // R3: an overrun write leaves the occupancy at the limit
    p_overrun_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !rd_en && !resp_load && !capturing && level == LIM)
        |=> level == LIM);

    // R5: a read of a non-empty queue raises the request next cycle
    p_irq_pop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !resp_load && level != '0) |=> irq);

    // R7: no request without a byte-removing read
    p_irq_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && !resp_load && level != '0) |=> !irq);

    // R6: outbound phase reads give zero
    p_outbound_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !resp_load && level != '0 && phase[2:1] == 2'b00)
        |=> rd_data == '0);

    // R4: captured writes do not touch occupancy
    p_capture_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && capturing && !rd_en && !resp_load)
        |=> level == $past(level));

    // R9: response load leaves two bytes and flags of two
    p_resp_r9: assert property (@(posedge clk) disable iff (!rst_n)
        resp_load |=> (level == TWO && resp_flags == W'(2)
                       && rptr == '0 && wptr == '0));

    // R8: draining the queue returns both pointers to slot zero
    p_drain_ptr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !resp_load && level == ONE) |=> (rptr == '0 && wptr == '0));
endmodule

bind hfifo_top hfifo_checker #(.DEPTH(DEPTH), .W(W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .resp_load  (resp_load),
    .capturing  (capturing),
    .phase      (phase),
    .level      (level),
    .rd_data    (rd_data),
    .irq        (irq),
    .resp_flags (resp_flags),
    .rptr       (rptr),
    .wptr       (wptr)
);

// File: tb/tb_hfifo_top.sv
`timescale 1ns/1ps
module tb_hfifo_top;
    localparam int DEPTH = 16;
    localparam int CMDD  = 32;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 0, rd_en = 0, cap_set = 0, cap_clr = 0, resp_load = 0;
    logic [7:0] wr_data = 0, resp_status = 0;
    logic [2:0] phase = 3'b010;
    logic [4:0] cmd_idx = 0;
    logic [7:0] rd_data, cmd_byte, resp_flags;
    logic       irq, capturing;
    logic [4:0] level;
    logic [5:0] cmd_len;

    int total = 0, bad = 0;
    bit finished = 0;

    // reference model state (after the next edge)
    logic [7:0] mm [DEPTH];
    int         mrp, mwp, mocc, mlen;
    logic [7:0] mrd, mflags;
    logic       mirq, mcap;
    logic [7:0] mcmd [CMDD];

    always #2.5 clk = ~clk;

    hfifo_top dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .irq(irq), .phase(phase),
        .level(level), .cap_set(cap_set), .cap_clr(cap_clr),
        .capturing(capturing), .cmd_len(cmd_len), .cmd_idx(cmd_idx),
        .cmd_byte(cmd_byte), .resp_load(resp_load),
        .resp_status(resp_status), .resp_flags(resp_flags)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < DEPTH; i++) mm[i] = 0;
        for (int i = 0; i < CMDD; i++) mcmd[i] = 0;
        mrp = 0; mwp = 0; mocc = 0; mlen = 0;
        mrd = 0; mflags = 0; mirq = 0; mcap = 0;
    endtask

    // model of one clock edge from the current inputs
    task automatic model_step();
        bit cmdpush;
        cmdpush = wr_en && mcap && !rd_en && !resp_load;
        mirq = 0;
        if (resp_load) begin
            mm[0] = resp_status; mm[1] = 0; mocc = 2; mrp = 0; mwp = 0; mflags = 2;
        end else if (rd_en) begin
            if (mocc > 0) begin
                mocc--; mirq = 1;
                if (phase[2:1] == 2'b00) mrd = 0;
                else begin mrd = mm[mrp]; mrp = (mrp + 1) % DEPTH; end
            end
            if (mocc == 0) begin mrp = 0; mwp = 0; end
        end else if (wr_en && !mcap) begin
            if (mocc != DEPTH - 1) begin
                mm[mwp] = wr_data; mwp = (mwp + 1) % DEPTH; mocc++;
            end
        end
        if (cmdpush && mlen < CMDD) begin mcmd[mlen] = wr_data; mlen++; end
        if (cap_clr) mcap = 0;
        else if (cap_set) begin mcap = 1; mlen = 0; end
    endtask

    task automatic compare_all();
        chk("R2 level", int'(level), mocc);
        chk("R5 rd_data", int'(rd_data), int'(mrd));
        chk("R5 irq", int'(irq), int'(mirq));
        chk("R9 resp_flags", int'(resp_flags), int'(mflags));
        chk("R11 capturing", int'(capturing), int'(mcap));
        chk("R4 cmd_len", int'(cmd_len), mlen);
        if (int'(cmd_idx) < mlen) chk("R4 cmd_byte", int'(cmd_byte), int'(mcmd[cmd_idx]));
    endtask

    task automatic idle_inputs();
        wr_en = 0; rd_en = 0; cap_set = 0; cap_clr = 0; resp_load = 0;
    endtask

    // drive current inputs for one edge, then check at the next falling edge
    task automatic tick();
        model_step();
        @(negedge clk);
        compare_all();
        idle_inputs();
    endtask

    task automatic do_write(input logic [7:0] b);
        wr_en = 1; wr_data = b; tick();
    endtask

    task automatic do_read(input logic [2:0] ph);
        rd_en = 1; phase = ph; tick();
    endtask

    initial begin : watchdog
        #(200000 * 5.0);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'h1d7a));
        model_reset();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        chk("R1 level", int'(level), 0);
        chk("R1 rd_data", int'(rd_data), 0);
        chk("R1 irq", int'(irq), 0);
        chk("R1 flags", int'(resp_flags), 0);
        chk("R1 capturing", int'(capturing), 0);
        chk("R1 cmd_len", int'(cmd_len), 0);

        // R2/R3: fill to 15, then an overrun write
        for (int i = 0; i < 16; i++) do_write(8'(8'h30 + i));
        chk("R3 level at limit", int'(level), 15);
        for (int i = 0; i < 15; i++) begin
            do_read(3'b010);
            chk("R2 order", int'(rd_data), 8'h30 + i);
        end
        // R7: empty read keeps data, no irq
        do_read(3'b010);
        chk("R7 hold", int'(rd_data), 8'h3e);
        chk("R7 irq", int'(irq), 0);

        // R6 skip replay, R8 drain reset
        do_write(8'hA1); do_write(8'hA2);
        do_read(3'b000);
        chk("R6 zero", int'(rd_data), 0);
        do_read(3'b110);
        chk("R6 replay", int'(rd_data), 8'hA1);
        do_write(8'hB5); do_write(8'hB6); do_write(8'hB7);
        do_read(3'b001); do_read(3'b001); do_read(3'b001);
        chk("R8 drained", int'(level), 0);
        do_write(8'hC9);
        do_read(3'b010);
        chk("R8 first byte after drain", int'(rd_data), 8'hC9);

        // R10: read and write together
        do_write(8'h11);
        wr_en = 1; wr_data = 8'h22; rd_en = 1; phase = 3'b010; tick();
        chk("R10 read served", int'(rd_data), 8'h11);
        chk("R10 write dropped", int'(level), 0);

        // R9 response load beats a write
        resp_load = 1; resp_status = 8'h02; wr_en = 1; wr_data = 8'h77; tick();
        chk("R9 level", int'(level), 2);
        do_read(3'b111);
        chk("R9 status byte", int'(rd_data), 8'h02);
        do_read(3'b111);
        chk("R9 second byte", int'(rd_data), 0);

        // R4/R11 capture, fill past the buffer
        cap_set = 1; tick();
        for (int i = 0; i < CMDD + 2; i++) do_write(8'(i * 3 + 1));
        chk("R4 cmd full", int'(cmd_len), CMDD);
        chk("R4 queue untouched", int'(level), 0);
        cmd_idx = 5; @(negedge clk);
        chk("R4 cmd entry", int'(cmd_byte), 16);
        cap_clr = 1; cap_set = 1; tick();
        chk("R11 clr wins", int'(capturing), 0);
        chk("R11 len kept", int'(cmd_len), CMDD);

        // random traffic
        for (int n = 0; n < 3000; n++) begin
            int r;
            r = int'($urandom_range(0, 99));
            wr_data = 8'($urandom); resp_status = 8'($urandom);
            phase = ($urandom_range(0, 3) == 0) ? 3'b000 : 3'($urandom_range(2, 7));
            cmd_idx = 5'($urandom);
            wr_en = (r < 45) || (r >= 90 && r < 94);
            rd_en = (r >= 45 && r < 80) || (r >= 90 && r < 94);
            resp_load = (r >= 94 && r < 96);
            cap_set = (r == 96 || r == 97);
            cap_clr = (r == 98);
            tick();
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule